// File: doc/BRIEF.md
# Evaluation-Stack Maintenance and Check Unit

This unit holds the evaluation stack of a 16-bit stack machine and carries out the instructions that rearrange that stack or test values on it. One command is accepted per handshake. The unit can push a literal, re-expose a word left above the top, drop the top, copy it, swap the top two words, test the top word or the top word pair for a zero pointer, and test an index against a limit. After each command it reports the new depth and the two topmost words.

A failed pointer or range test raises a trap strobe with a code. The checks inspect their operands in place: the pointer tests leave the stack as it was, and the range test removes only the limit. A command that would read below the bottom, write past the top, or re-expose more than the permitted number of stale words raises a stack error instead and changes nothing. Trap dispatch and memory traffic belong to the surrounding machine.

The command input follows valid/ready rules. A command transfers on a rising edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is low during reset and high from the first edge after reset. The unit never applies back-pressure after that, so the sender can keep `cmd_valid` asserted for as many cycles as it likes. Results are not back-pressured: `done` is a plain one-cycle strobe.

Top module: `stack_guard_unit`

## Requirements
- R1: While reset is applied and on the first cycle after it, depth is 0, `tos` and `nos` are 0, and `done`, `trap`, `stack_err` and `trap_code` are all 0.
- R2: `cmd_ready` is high from the first edge after reset. Every accepted command raises `done` on the following cycle for exactly one cycle.
- R3: Opcode 0 (literal) writes `cmd_lit` above the top and increments depth. It also clears the count of words that can be re-exposed.
- R4: Opcode 1 (raise) increments depth without writing, so the word left there earlier becomes the top. Each drop or range test makes one more word available for this, up to 2 words. A raise when no word is available raises `stack_err` and changes nothing.
- R5: Opcode 2 (drop) decrements depth and leaves the dropped word stored so that a later raise shows it again.
- R6: Opcode 3 (copy) pushes a second copy of the top word.
- R7: Opcode 4 (swap) exchanges the top two words and leaves depth unchanged.
- R8: Opcode 5 (pointer test) leaves the stack unchanged. It raises `trap` with `trap_code` 1 when the top word is 0.
- R9: Opcode 6 (long pointer test) treats the top two words as one 32-bit pointer and leaves both on the stack. It raises `trap` with `trap_code` 1 only when both words are 0.
- R10: Opcode 7 (range test) takes the limit from the top and the index from the word below it. It removes the limit and leaves the index on top. It raises `trap` with `trap_code` 2 when index >= limit as unsigned values.
- R11: A command whose operands are missing (depth too small) or whose result would not fit (depth 8 with the default size) raises `stack_err`. It leaves depth and contents unchanged and raises no trap.
- R12: `trap` and `stack_err` are only ever high together with `done`. `trap_code` is 0 whenever `trap` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 3 | Opcode, 0 to 7 as listed in the requirements |
| cmd_lit | input | W (16) | Literal for opcode 0 |
| done | output | 1 | One-cycle completion strobe |
| trap | output | 1 | A check failed on the completed command |
| trap_code | output | 2 | 1 pointer fault, 2 range fault, 0 otherwise |
| stack_err | output | 1 | Completed command was illegal and had no effect |
| depth | output | clog2(DEPTH+1) | Number of live words |
| tos | output | W | Top word, 0 when depth is 0 |
| nos | output | W | Word below the top, 0 when depth < 2 |

## Verification
The bench works through the re-expose budget. It drops three times and then raises three times, so the third raise must fail. A design that lets the count wrap, or that forgets to clear it after a literal, would expose a wrong word or accept that raise. The range test is driven with an equal index and limit, with an index of 0x8000 against a limit of 1, and with a limit of 0xFFFF. A strict or signed comparator would miss a trap or raise a false one. The long pointer test is given one zero word and one non-zero word, which catches a design that tests only the top. The bench also fills the stack to the top and runs every operation on an empty or single-word stack, which exposes a design that wraps the pointer or corrupts its contents.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_LIT   = 3'd0,
    OP_RAISE = 3'd1,
    OP_DROP  = 3'd2,
    OP_COPY  = 3'd3,
    OP_SWAP  = 3'd4,
    OP_ZCHK  = 3'd5,
    OP_ZCHK2 = 3'd6,
    OP_RANGE = 3'd7
  } stk_op_e;

  localparam logic [1:0] TRAP_NONE  = 2'd0;
  localparam logic [1:0] TRAP_PTR   = 2'd1;
  localparam logic [1:0] TRAP_RANGE = 2'd2;
endpackage

// File: rtl/stk_file.sv
module stk_file #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [W-1:0]  data_a,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [W-1:0]  data_b,
  input  logic [AW-1:0] addr_t,
  input  logic [AW-1:0] addr_n,
  output logic [W-1:0]  rd_t,
  output logic [W-1:0]  rd_n
);
  logic [W-1:0] rows [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_row
    logic [W-1:0] q;
    always_ff @(posedge clk) begin
      if (we_a && addr_a == AW'(g))      q <= data_a;
      else if (we_b && addr_b == AW'(g)) q <= data_b;
    end
    assign rows[g] = q;
  end

  assign rd_t = rows[addr_t];
  assign rd_n = rows[addr_n];
endmodule

// File: rtl/stk_check.sv
module stk_check
  import stk_pkg::*;
#(
  parameter int W = 16
) (
  input  stk_op_e      op,
  input  logic [W-1:0] tos,
  input  logic [W-1:0] nos,
  output logic         ptr_fault,
  output logic         range_fault
);
  logic top_zero, pair_zero;

  assign top_zero  = (tos == '0);
  assign pair_zero = ((tos | nos) == '0);

  always_comb begin
    ptr_fault   = 1'b0;
    range_fault = 1'b0;
    unique case (op)
      OP_ZCHK:  ptr_fault   = top_zero;
      OP_ZCHK2: ptr_fault   = pair_zero;
      OP_RANGE: range_fault = (nos >= tos);
      default: ;
    endcase
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 8,
  parameter int REEXPOSE = 2,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW      = $clog2(DEPTH + 1),
  localparam int SW      = $clog2(REEXPOSE + 1)
) (
  input  stk_op_e       op,
  input  logic [W-1:0]  lit,
  input  logic [W-1:0]  tos,
  input  logic [W-1:0]  nos,
  input  logic [PW-1:0] sp,
  input  logic [SW-1:0] spare,
  output logic          legal,
  output logic          we_a,
  output logic [AW-1:0] addr_a,
  output logic [W-1:0]  data_a,
  output logic          we_b,
  output logic [AW-1:0] addr_b,
  output logic [W-1:0]  data_b,
  output logic [PW-1:0] sp_nx,
  output logic [SW-1:0] spare_nx
);
  localparam logic [PW-1:0] FULL = PW'(DEPTH);
  localparam logic [SW-1:0] SMAX = SW'(REEXPOSE);

  logic          has1, has2, room;
  logic [AW-1:0] free_a, top_a, sec_a;
  logic [PW-1:0] sp_up, sp_dn;
  logic [SW-1:0] spare_up;

  assign has1     = (sp != '0);
  assign has2     = (sp > PW'(1));
  assign room     = (sp < FULL);
  assign sp_up    = sp + PW'(1);
  assign sp_dn    = sp - PW'(1);
  assign free_a   = AW'(sp);
  assign top_a    = AW'(sp - PW'(1));
  assign sec_a    = AW'(sp - PW'(2));
  assign spare_up = (spare == SMAX) ? spare : spare + SW'(1);

  always_comb begin
    legal    = 1'b0;
    we_a     = 1'b0;
    addr_a   = free_a;
    data_a   = lit;
    we_b     = 1'b0;
    addr_b   = sec_a;
    data_b   = tos;
    sp_nx    = sp;
    spare_nx = spare;
    unique case (op)
      OP_LIT: begin
        legal    = room;
        we_a     = 1'b1;
        sp_nx    = sp_up;
        spare_nx = '0;
      end
      OP_RAISE: begin
        legal    = (spare != '0) && room;
        sp_nx    = sp_up;
        spare_nx = spare - SW'(1);
      end
      OP_DROP: begin
        legal    = has1;
        sp_nx    = sp_dn;
        spare_nx = spare_up;
      end
      OP_COPY: begin
        legal    = has1 && room;
        we_a     = 1'b1;
        data_a   = tos;
        sp_nx    = sp_up;
        spare_nx = '0;
      end
      OP_SWAP: begin
        legal  = has2;
        we_a   = 1'b1;
        addr_a = top_a;
        data_a = nos;
        we_b   = 1'b1;
      end
      OP_ZCHK:  legal = has1;
      OP_ZCHK2: legal = has2;
      OP_RANGE: begin
        legal    = has2;
        sp_nx    = sp_dn;
        spare_nx = spare_up;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stack_guard_unit.sv
module stack_guard_unit
  import stk_pkg::*;
#(
  parameter int W        = 16,
  parameter int DEPTH    = 8,
  parameter int REEXPOSE = 2,
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW      = $clog2(DEPTH + 1),
  localparam int SW      = $clog2(REEXPOSE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [W-1:0]  cmd_lit,
  output logic          done,
  output logic          trap,
  output logic [1:0]    trap_code,
  output logic          stack_err,
  output logic [PW-1:0] depth,
  output logic [W-1:0]  tos,
  output logic [W-1:0]  nos
);
  stk_op_e       op;
  logic          accept, legal;
  logic          we_a, we_b;
  logic [AW-1:0] addr_a, addr_b, addr_t, addr_n;
  logic [W-1:0]  data_a, data_b, rd_t, rd_n;
  logic [PW-1:0] sp_q, sp_nx;
  logic [SW-1:0] spare_q, spare_nx;
  logic          ptr_fault, range_fault;
  logic          rdy_q, done_q, trap_q, err_q;
  logic [1:0]    code_q;

  assign op     = stk_op_e'(cmd_op);
  assign accept = cmd_valid && rdy_q;
  assign addr_t = AW'(sp_q - PW'(1));
  assign addr_n = AW'(sp_q - PW'(2));

  stk_file #(.W(W), .DEPTH(DEPTH)) u_file (
    .clk    (clk),
    .we_a   (we_a && legal && accept),
    .addr_a (addr_a),
    .data_a (data_a),
    .we_b   (we_b && legal && accept),
    .addr_b (addr_b),
    .data_b (data_b),
    .addr_t (addr_t),
    .addr_n (addr_n),
    .rd_t   (rd_t),
    .rd_n   (rd_n)
  );

  stk_ctrl #(.W(W), .DEPTH(DEPTH), .REEXPOSE(REEXPOSE)) u_ctrl (
    .op       (op),
    .lit      (cmd_lit),
    .tos      (tos),
    .nos      (nos),
    .sp       (sp_q),
    .spare    (spare_q),
    .legal    (legal),
    .we_a     (we_a),
    .addr_a   (addr_a),
    .data_a   (data_a),
    .we_b     (we_b),
    .addr_b   (addr_b),
    .data_b   (data_b),
    .sp_nx    (sp_nx),
    .spare_nx (spare_nx)
  );

  stk_check #(.W(W)) u_check (
    .op          (op),
    .tos         (tos),
    .nos         (nos),
    .ptr_fault   (ptr_fault),
    .range_fault (range_fault)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      sp_q    <= '0;
      spare_q <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= TRAP_NONE;
    end else begin
      rdy_q  <= 1'b1;
      done_q <= accept;
      err_q  <= accept && !legal;
      trap_q <= accept && legal && (ptr_fault || range_fault);
      if (accept && legal) begin
        sp_q    <= sp_nx;
        spare_q <= spare_nx;
        code_q  <= ptr_fault   ? TRAP_PTR :
                   range_fault ? TRAP_RANGE : TRAP_NONE;
      end else begin
        code_q <= TRAP_NONE;
      end
    end
  end

  assign cmd_ready = rdy_q;
  assign done      = done_q;
  assign trap      = trap_q;
  assign trap_code = code_q;
  assign stack_err = err_q;
  assign depth     = sp_q;
  assign tos       = (sp_q != '0)     ? rd_t : '0;
  assign nos       = (sp_q > PW'(1))  ? rd_n : '0;
endmodule

// File: rtl/stack_guard_unit_chk.sv
module stack_guard_unit_chk #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic          done,
  input logic          trap,
  input logic [1:0]    trap_code,
  input logic          stack_err,
  input logic [PW-1:0] depth,
  input logic [W-1:0]  tos
);
  a_r2_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> done);

  a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) |=> !done);

  a_r12_trap_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (done && (trap_code == 2'd1 || trap_code == 2'd2)));

  a_r12_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trap |-> (trap_code == 2'd0));

  a_r11_err_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    stack_err |-> (done && !trap && $stable(depth) && $stable(tos)));

  a_r4_raise_step: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stack_err && $past(cmd_op) == 3'd1) |-> (depth == $past(depth) + PW'(1)));

  a_r8_ptr_test_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(cmd_op) == 3'd5) |-> ($stable(depth) && $stable(tos)));

  a_r10_range_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stack_err && $past(cmd_op) == 3'd7) |-> (depth == $past(depth) - PW'(1)));

  a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= PW'(DEPTH));
endmodule

bind stack_guard_unit stack_guard_unit_chk #(.W(W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .done      (done),
  .trap      (trap),
  .trap_code (trap_code),
  .stack_err (stack_err),
  .depth     (depth),
  .tos       (tos)
);

// File: tb/test_stack_guard_unit.sv
module test_stack_guard_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [15:0] cmd_lit;
  logic        done, trap, stack_err;
  logic [1:0]  trap_code;
  logic [3:0]  depth;
  logic [15:0] tos, nos;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  stack_guard_unit i_stack_guard_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_lit(cmd_lit), .done(done), .trap(trap),
    .trap_code(trap_code), .stack_err(stack_err), .depth(depth),
    .tos(tos), .nos(nos)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] lit;
    logic [3:0]  dep;
    logic [15:0] t;
    logic [15:0] n;
    logic        trp;
    logic [1:0]  code;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  typedef struct packed {
    logic [3:0]  dep;
    logic [15:0] t;
    logic [15:0] n;
    logic        trp;
    logic [1:0]  code;
    logic        err;
  } obs_t;

  // op, lit, depth, tos, nos, trap, code, err, requirement number
  localparam vec_t VEC [35] = '{
    '{3'd0, 16'h0005, 4'd1, 16'h0005, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd3},  // R3
    '{3'd0, 16'h0009, 4'd2, 16'h0009, 16'h0005, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd4, 16'h0000, 4'd2, 16'h0005, 16'h0009, 1'b0, 2'd0, 1'b0, 8'd7},  // R7 swap
    '{3'd7, 16'h0000, 4'd1, 16'h0009, 16'h0000, 1'b1, 2'd2, 1'b0, 8'd10}, // R10 9>=5
    '{3'd0, 16'h000A, 4'd2, 16'h000A, 16'h0009, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd7, 16'h0000, 4'd1, 16'h0009, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd10}, // R10 9<10
    '{3'd1, 16'h0000, 4'd2, 16'h000A, 16'h0009, 1'b0, 2'd0, 1'b0, 8'd4},  // R4 limit re-exposed
    '{3'd3, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd6},  // R6
    '{3'd5, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd8},  // R8 no trap
    '{3'd0, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd5, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b1, 2'd1, 1'b0, 8'd8},  // R8 trap
    '{3'd6, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd9},  // R9 one word nonzero
    '{3'd0, 16'h0000, 4'd5, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd6, 16'h0000, 4'd5, 16'h0000, 16'h0000, 1'b1, 2'd1, 1'b0, 8'd9},  // R9 both zero
    '{3'd2, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd5},  // R5
    '{3'd2, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd5},
    '{3'd2, 16'h0000, 4'd2, 16'h000A, 16'h0009, 1'b0, 2'd0, 1'b0, 8'd5},
    '{3'd1, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd4},  // R4 first
    '{3'd1, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd4},  // R4 second
    '{3'd1, 16'h0000, 4'd4, 16'h0000, 16'h000A, 1'b0, 2'd0, 1'b1, 8'd4},  // R4 third refused
    '{3'd7, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b1, 2'd2, 1'b0, 8'd10}, // R10 limit 0
    '{3'd0, 16'h000A, 4'd4, 16'h000A, 16'h000A, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd7, 16'h0000, 4'd3, 16'h000A, 16'h000A, 1'b1, 2'd2, 1'b0, 8'd10}, // R10 equal
    '{3'd7, 16'h0000, 4'd2, 16'h000A, 16'h0009, 1'b1, 2'd2, 1'b0, 8'd10},
    '{3'd7, 16'h0000, 4'd1, 16'h0009, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd10},
    '{3'd7, 16'h0000, 4'd1, 16'h0009, 16'h0000, 1'b0, 2'd0, 1'b1, 8'd11}, // R11 underflow
    '{3'd4, 16'h0000, 4'd1, 16'h0009, 16'h0000, 1'b0, 2'd0, 1'b1, 8'd11},
    '{3'd2, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd5},
    '{3'd2, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 8'd11},
    '{3'd5, 16'h0000, 4'd0, 16'h0000, 16'h0000, 1'b0, 2'd0, 1'b1, 8'd11},
    '{3'd0, 16'h8000, 4'd1, 16'h8000, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd0, 16'h0001, 4'd2, 16'h0001, 16'h8000, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd7, 16'h0000, 4'd1, 16'h8000, 16'h0000, 1'b1, 2'd2, 1'b0, 8'd10}, // R10 unsigned
    '{3'd0, 16'hFFFF, 4'd2, 16'hFFFF, 16'h8000, 1'b0, 2'd0, 1'b0, 8'd3},
    '{3'd7, 16'h0000, 4'd1, 16'h8000, 16'h0000, 1'b0, 2'd0, 1'b0, 8'd10}  // R10 limit FFFF
  };

  function automatic obs_t observe();
    return '{depth, tos, nos, trap, trap_code, stack_err};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Sends one command; returns at the negedge after the accepting edge.
  task automatic run_op(input logic [2:0] op, input logic [15:0] lit);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_lit   = lit;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic expect_state(input string req, input logic [3:0] d, input logic [15:0] t,
                              input logic e);
    obs_t exp_o;
    exp_o = '{d, t, nos, 1'b0, 2'd0, e};
    check(done && observe() == exp_o, req, {27'd0, done, observe()}, {27'd0, 1'b1, exp_o});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fails++;
    $display("FAIL R2: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cmd_valid = 1'b0;
    cmd_op    = 3'd0;
    cmd_lit   = '0;
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(depth == 0 && !done && !trap && !stack_err && trap_code == 0 && tos == 0 && nos == 0,
          "R1", {56'd0, depth, done, trap, stack_err, trap_code}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R2 ready", {63'd0, cmd_ready}, 64'd1);

    for (int i = 0; i < 35; i++) begin
      obs_t exp_o;
      run_op(VEC[i].op, VEC[i].lit);
      exp_o = '{VEC[i].dep, VEC[i].t, VEC[i].n, VEC[i].trp, VEC[i].code, VEC[i].err};
      n_checks++;
      if (!(done && observe() == exp_o)) begin
        n_fails++;
        $display("FAIL R%0d step %0d: actual=%h done=%b expected=%h done=1",
                 VEC[i].req, i, observe(), done, exp_o);
      end
    end

    // R2: done lasts one cycle
    @(negedge clk);
    check(!done && !trap && !stack_err && trap_code == 0, "R2 R12 strobe width",
          {60'd0, done, trap, stack_err, |trap_code}, 64'd0);

    // R1: reset in mid-run clears the stack
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(depth == 0 && !done && tos == 0, "R1 mid-run", {44'd0, depth, tos}, 64'd0);
    @(negedge clk);

    // R11: fill to the top, then overflow
    for (int k = 1; k <= 8; k++) run_op(3'd0, 16'(k));
    expect_state("R3 full", 4'd8, 16'd8, 1'b0);
    run_op(3'd0, 16'h1234);
    expect_state("R11 literal overflow", 4'd8, 16'd8, 1'b1);
    run_op(3'd3, 16'h0);
    expect_state("R11 copy overflow", 4'd8, 16'd8, 1'b1);
    run_op(3'd1, 16'h0);
    expect_state("R4 raise with nothing dropped", 4'd8, 16'd8, 1'b1);
    run_op(3'd2, 16'h0);
    expect_state("R5 drop at full", 4'd7, 16'd7, 1'b0);
    run_op(3'd1, 16'h0);
    expect_state("R4 raise back to full", 4'd8, 16'd8, 1'b0);

    // R2: held valid gives back-to-back commands
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'd5;
    @(negedge clk);
    check(done == 1'b1, "R2 first of pair", {63'd0, done}, 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    check(done == 1'b1 && depth == 8, "R2 second of pair", {59'd0, done, depth}, {59'd0, 1'b1, 4'd8});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule